// File: doc/BRIEF.md
# DMA Trigger Sequencer

This block moves data between two memory addresses one unit at a time, with no processor in the loop once it is configured. Software loads a source address, a destination address, a unit count, a unit size, a direction and a trigger choice through a small write-only register port, then writes the start bit. After that, each transfer step is started by hardware. The step can come from a device reporting that new input data is ready, from a device reporting that its output side has gone idle, or from a built-in periodic timer with a programmable reload.

In single mode, each trigger moves one unit. In burst mode, each trigger moves a block of up to a programmed length back to back, which drains or fills a device-side buffer in one sequence. Each unit is presented on a request/grant memory port and is held there until it is granted. When the last unit is granted, a completion interrupt is raised. The interrupt stays high until software writes the clear bit.

The controller has three states. `ST_IDLE` means no job is running. `ST_ARMED` means a job is running and the block is waiting for a trigger. `ST_XFER` means a unit is being requested. The transitions are named as follows:
- T_START goes from idle to armed on a start write with a nonzero count.
- T_ZERO stays in idle on a start write with a zero count, and raises the interrupt.
- T_FIRE goes from armed to transfer when the selected trigger is seen.
- T_BURST_NEXT stays in transfer when a granted unit leaves more of the burst to move.
- T_REARM goes from transfer back to armed when a granted unit ends the burst or the single unit.
- T_FINISH goes from transfer to idle when the granted unit is the last one, and raises the interrupt.

Top module: `dma_trig_seq`

## Requirements
- R1: During and after reset, `mem_req` and `irq` are 0.
- R2: Register addresses are: 0 source, 1 destination, 2 unit count, 3 timer reload, 4 burst length, 5 control, 6 interrupt clear. The control bits are: bit0 start, bit1 backward, bits3:2 size code, bits5:4 trigger select, bit6 burst. All writes except the interrupt clear are accepted only in idle. A write while a job runs changes nothing that the running job uses.
- R3: With trigger select 0, a high `trig_data_rdy` sampled while armed starts a transfer. `mem_req` goes high after that clock edge.
- R4: With trigger select 1, a high `trig_out_idle` sampled while armed starts a transfer in the same way.
- R5: With trigger select 2, the timer produces a one-cycle strobe every reload+1 cycles. The timer starts at the start write. The first request appears reload+1 clock edges after the start write is captured. Later requests are reload+1 edges apart.
- R6: Size code 0, 1 or 2 selects a unit of 1, 2 or 4 bytes. After each granted unit, the source and destination both move by one unit size. They increase in forward mode and decrease in backward mode, and they wrap modulo 2^32. `mem_size` carries the size code.
- R7: In single mode, each trigger moves exactly one unit.
- R8: In burst mode, each trigger moves min(burst length, remaining count) units back to back, without a further trigger.
- R9: A request is held, with stable addresses, until `mem_gnt`. Triggers that arrive while a unit waits for grant are dropped and are not queued.
- R10: After the unit count has been moved, `irq` is 1 and no further request is made, even if triggers keep arriving.
- R11: `irq` stays 1 until a write of 1 to bit0 of the clear register. Writing 0 there leaves it set.
- R12: A start write with a unit count of 0 raises `irq` at once and makes no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | AW | Register write data |
| trig_data_rdy | input | 1 | Input device has new data |
| trig_out_idle | input | 1 | Output device is idle |
| mem_req | output | 1 | Unit transfer request |
| mem_src | output | AW | Source address of the current unit |
| mem_dst | output | AW | Destination address of the current unit |
| mem_size | output | 2 | Unit size code |
| mem_gnt | input | 1 | Memory accepted the current unit |
| irq | output | 1 | Completion interrupt, sticky |

## Verification
A wrong address or count register shows up on `mem_src`/`mem_dst` at the very next request. A bad count also shows up as `irq` rising one unit early or late. A state machine stuck in the wrong state shows as a request that never drops or never appears within a few cycles of a trigger. It also shows as a second unit that appears without a trigger after a dropped one. A timer that is off by one moves the first request, and every later one, by one cycle against reload+1.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_XFER  = 2'd2
    } dma_state_e;

    typedef enum logic [1:0] {
        TRG_DATA  = 2'd0,
        TRG_IDLE  = 2'd1,
        TRG_TIMER = 2'd2,
        TRG_NONE  = 2'd3
    } dma_trig_e;

    localparam logic [2:0] REG_SRC    = 3'd0;
    localparam logic [2:0] REG_DST    = 3'd1;
    localparam logic [2:0] REG_COUNT  = 3'd2;
    localparam logic [2:0] REG_RELOAD = 3'd3;
    localparam logic [2:0] REG_BLEN   = 3'd4;
    localparam logic [2:0] REG_CTRL   = 3'd5;
    localparam logic [2:0] REG_IRQCLR = 3'd6;

    localparam int CTRL_GO    = 0;
    localparam int CTRL_BACK  = 1;
    localparam int CTRL_SZ_LO = 2;
    localparam int CTRL_SZ_HI = 3;
    localparam int CTRL_TS_LO = 4;
    localparam int CTRL_TS_HI = 5;
    localparam int CTRL_BURST = 6;

endpackage

// File: rtl/dma_period_timer.sv
module dma_period_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [TW-1:0] reload,
    output logic          tick
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= reload;
        end else if (cnt_q == '0) begin
            cnt_q <= reload;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        tick = run && (cnt_q == '0);
    end

    // Strobe lasts one cycle when the period exceeds one cycle
    assert_tick_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && reload != '0) |=> !tick);

endmodule

// File: rtl/dma_trig_mux.sv
module dma_trig_mux
    import dma_pkg::*;
(
    input  dma_trig_e sel,
    input  logic      armed,
    input  logic      data_rdy,
    input  logic      out_idle,
    input  logic      tick,
    output logic      fire
);
    logic picked;

    always_comb begin
        unique case (sel)
            TRG_DATA:  picked = data_rdy;
            TRG_IDLE:  picked = out_idle;
            TRG_TIMER: picked = tick;
            default:   picked = 1'b0;
        endcase
        fire = armed && picked;
    end

endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr,
    input  logic [1:0]    size,
    input  logic          back,
    output logic [AW-1:0] nxt
);
    logic [AW-1:0] step;

    always_comb begin
        unique case (size)
            2'd0:    step = AW'(1);
            2'd1:    step = AW'(2);
            default: step = AW'(4);
        endcase
        nxt = back ? (addr - step) : (addr + step);
    end

endmodule

// File: rtl/dma_trig_seq.sv
module dma_trig_seq
    import dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int BW = 8,
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_addr,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          trig_data_rdy,
    input  logic          trig_out_idle,
    output logic          mem_req,
    output logic [AW-1:0] mem_src,
    output logic [AW-1:0] mem_dst,
    output logic [1:0]    mem_size,
    input  logic          mem_gnt,
    output logic          irq
);
    localparam int NCH = 2;

    dma_state_e    state_q, state_d;
    logic [AW-1:0] src_q, dst_q;
    logic [CW-1:0] cnt_q;
    logic [TW-1:0] reload_q;
    logic [BW-1:0] blen_q, bleft_q;
    logic [1:0]    size_q;
    logic          back_q, burst_q, irq_q;
    dma_trig_e     sel_q;

    logic wr_idle, go_wr, clr_wr, fire, tick, timer_run;
    logic unit_done, last_unit, more_burst, irq_set;
    logic [AW-1:0] cur_addr [NCH];
    logic [AW-1:0] nxt_addr [NCH];

    // Decoding of register writes
    always_comb begin
        wr_idle    = cfg_we && (state_q == ST_IDLE);
        go_wr      = wr_idle && (cfg_addr == REG_CTRL) && cfg_wdata[CTRL_GO];
        clr_wr     = cfg_we && (cfg_addr == REG_IRQCLR) && cfg_wdata[0];
        unit_done  = (state_q == ST_XFER) && mem_gnt;
        last_unit  = (cnt_q == CW'(1));
        more_burst = burst_q && (bleft_q > BW'(1));
        irq_set    = (unit_done && last_unit) || (go_wr && cnt_q == '0);
        timer_run  = (state_q != ST_IDLE) && (sel_q == TRG_TIMER);
    end

    dma_period_timer #(.TW(TW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (timer_run),
        .reload (reload_q),
        .tick   (tick)
    );

    dma_trig_mux u_mux (
        .sel      (sel_q),
        .armed    (state_q == ST_ARMED),
        .data_rdy (trig_data_rdy),
        .out_idle (trig_out_idle),
        .tick     (tick),
        .fire     (fire)
    );

    assign cur_addr[0] = src_q;
    assign cur_addr[1] = dst_q;

    for (genvar g = 0; g < NCH; g++) begin : g_step
        dma_addr_step #(.AW(AW)) u_step (
            .addr (cur_addr[g]),
            .size (size_q),
            .back (back_q),
            .nxt  (nxt_addr[g])
        );
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state with named transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go_wr && cnt_q != '0) state_d = ST_ARMED;   // T_START (T_ZERO stays)
            end
            ST_ARMED: begin
                if (fire) state_d = ST_XFER;                    // T_FIRE
            end
            ST_XFER: begin
                if (mem_gnt) begin
                    if (last_unit)       state_d = ST_IDLE;     // T_FINISH
                    else if (more_burst) state_d = ST_XFER;     // T_BURST_NEXT
                    else                 state_d = ST_ARMED;    // T_REARM
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Job registers and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q    <= '0;
            dst_q    <= '0;
            cnt_q    <= '0;
            reload_q <= '0;
            blen_q   <= '0;
            bleft_q  <= '0;
            size_q   <= '0;
            back_q   <= 1'b0;
            burst_q  <= 1'b0;
            sel_q    <= TRG_DATA;
            irq_q    <= 1'b0;
        end else begin
            if (wr_idle) begin
                case (cfg_addr)
                    REG_SRC:    src_q    <= cfg_wdata;
                    REG_DST:    dst_q    <= cfg_wdata;
                    REG_COUNT:  cnt_q    <= cfg_wdata[CW-1:0];
                    REG_RELOAD: reload_q <= cfg_wdata[TW-1:0];
                    REG_BLEN:   blen_q   <= cfg_wdata[BW-1:0];
                    REG_CTRL: begin
                        back_q  <= cfg_wdata[CTRL_BACK];
                        size_q  <= cfg_wdata[CTRL_SZ_HI:CTRL_SZ_LO];
                        sel_q   <= dma_trig_e'(cfg_wdata[CTRL_TS_HI:CTRL_TS_LO]);
                        burst_q <= cfg_wdata[CTRL_BURST];
                    end
                    default: ;
                endcase
            end
            if (fire) begin
                bleft_q <= blen_q;
            end
            if (unit_done) begin
                src_q   <= nxt_addr[0];
                dst_q   <= nxt_addr[1];
                cnt_q   <= cnt_q - 1'b1;
                bleft_q <= bleft_q - 1'b1;
            end
            if (irq_set) begin
                irq_q <= 1'b1;
            end else if (clr_wr) begin
                irq_q <= 1'b0;
            end
        end
    end

    // Outputs
    always_comb begin
        mem_req  = (state_q == ST_XFER);
        mem_src  = src_q;
        mem_dst  = dst_q;
        mem_size = size_q;
        irq      = irq_q;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!mem_req && !irq));

    assert_hold_until_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_src) && $stable(mem_dst)));

    assert_channels_step_alike_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_gnt && !last_unit) |=>
        ((mem_src - $past(mem_src)) == (mem_dst - $past(mem_dst))));

    assert_finish_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_gnt && last_unit) |=> (irq && !mem_req));

    assert_irq_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_wr) |=> irq);

    assert_zero_count_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (go_wr && cnt_q == '0) |=> (irq && !mem_req));

endmodule

// File: tb/dma_trig_seq_tb.sv
`timescale 1ns/1ps
module dma_trig_seq_tb_top;
    import dma_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [2:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic        trig_data_rdy, trig_out_idle;
    logic        mem_req, mem_gnt, irq;
    logic [31:0] mem_src, mem_dst;
    logic [1:0]  mem_size;

    always #2.5 clk = ~clk;

    dma_trig_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .trig_data_rdy(trig_data_rdy),
        .trig_out_idle(trig_out_idle), .mem_req(mem_req), .mem_src(mem_src),
        .mem_dst(mem_dst), .mem_size(mem_size), .mem_gnt(mem_gnt), .irq(irq)
    );

    // Vector: src16 dst16 count8 size2 back1 burst1 blen4 trig2 reload8
    localparam logic [57:0] VEC [0:5] = '{
        {16'h1000, 16'h2000, 8'd4, 2'd0, 1'b0, 1'b0, 4'd1, 2'd0, 8'd0},
        {16'h3000, 16'h4000, 8'd3, 2'd1, 1'b1, 1'b0, 4'd1, 2'd1, 8'd0},
        {16'h0100, 16'h8000, 8'd5, 2'd2, 1'b0, 1'b1, 4'd2, 2'd0, 8'd0},
        {16'h7FF0, 16'h0010, 8'd6, 2'd2, 1'b1, 1'b1, 4'd4, 2'd1, 8'd0},
        {16'h0040, 16'h0080, 8'd3, 2'd1, 1'b0, 1'b0, 4'd1, 2'd2, 8'd3},
        {16'h0002, 16'h0010, 8'd4, 2'd0, 1'b1, 1'b1, 4'd8, 2'd0, 8'd0}
    };

    int n_tests = 0, n_fail = 0, s_tests = 0, s_fail = 0;
    int units_total = 0, unit_base = 0;
    logic [31:0] base_src = '0, base_dst = '0;
    logic [1:0]  exp_size = '0;
    logic        exp_back = 1'b0;
    bit          gnt_hold = 1'b0;
    bit          finished = 1'b0;
    logic [31:0] st_off, st_es, st_ed;

    // Memory stub: grants each request on the next edge and checks the unit (R6)
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_gnt <= 1'b0;
        end else if (mem_req && !mem_gnt && !gnt_hold) begin
            st_off = 32'(units_total - unit_base) << exp_size;
            st_es  = exp_back ? base_src - st_off : base_src + st_off;
            st_ed  = exp_back ? base_dst - st_off : base_dst + st_off;
            s_tests += 3;
            if (mem_src !== st_es) begin
                s_fail++; $display("FAIL R6 src actual=%0h expected=%0h", mem_src, st_es);
            end
            if (mem_dst !== st_ed) begin
                s_fail++; $display("FAIL R6 dst actual=%0h expected=%0h", mem_dst, st_ed);
            end
            if (mem_size !== exp_size) begin
                s_fail++; $display("FAIL R6 size actual=%0h expected=%0h", mem_size, exp_size);
            end
            units_total <= units_total + 1;
            mem_gnt <= 1'b1;
        end else begin
            mem_gnt <= 1'b0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_wr(input logic [2:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse(input logic [1:0] which);
        if (which == 2'd0) trig_data_rdy = 1'b1; else trig_out_idle = 1'b1;
        @(posedge clk);
        @(negedge clk);
        trig_data_rdy = 1'b0; trig_out_idle = 1'b0;
    endtask

    task automatic wait_req_low();
        for (int w = 0; w < 64 && mem_req; w++) @(negedge clk);
    endtask

    task automatic wait_req_high();
        for (int w = 0; w < 64 && !mem_req; w++) @(negedge clk);
    endtask

    task automatic start_job(input logic [31:0] s, input logic [31:0] d, input int cnt,
                             input logic [1:0] sz, input logic bk, input logic bu,
                             input int bl, input logic [1:0] tr, input int rl);
        cfg_wr(REG_SRC, s);
        cfg_wr(REG_DST, d);
        cfg_wr(REG_COUNT, 32'(cnt));
        cfg_wr(REG_RELOAD, 32'(rl));
        cfg_wr(REG_BLEN, 32'(bl));
        base_src = s; base_dst = d; exp_size = sz; exp_back = bk;
        unit_base = units_total;
        cfg_wr(REG_CTRL, {25'd0, bu, tr, sz, bk, 1'b1});
    endtask

    task automatic run_vector(input int i);
        logic [57:0] v;
        logic [1:0]  tr;
        int rem, expu, start, cnt, bl;
        logic bu;
        string ttag;
        v   = VEC[i];
        cnt = int'(v[25:18]);
        bu  = v[14];
        bl  = int'(v[13:10]);
        tr  = v[9:8];
        ttag = (tr == 2'd0) ? "R3 data-ready start" :
               (tr == 2'd1) ? "R4 out-idle start" : "R5 timer start";
        start_job({16'd0, v[57:42]}, {16'd0, v[41:26]}, cnt, v[17:16], v[15], bu, bl, tr,
                  int'(v[7:0]));
        rem = cnt;
        while (rem > 0) begin
            expu  = bu ? ((bl < rem) ? bl : rem) : 1;
            start = units_total;
            if (tr == 2'd2) begin
                wait_req_high();
            end else begin
                pulse(tr);
            end
            if (rem == cnt) chk(ttag, {31'd0, mem_req}, 32'd1);
            wait_req_low();
            if (bu) chk("R8 units per trigger", 32'(units_total - start), 32'(expu));
            else    chk("R7 units per trigger", 32'(units_total - start), 32'(expu));
            rem -= expu;
        end
        chk("R10 irq at completion", {31'd0, irq}, 32'd1);
        if (tr != 2'd2) pulse(tr);
        repeat (6) @(negedge clk);
        chk("R10 no request after completion", {31'd0, mem_req}, 32'd0);
        cfg_wr(REG_IRQCLR, 32'd1);
    endtask

    initial begin
        int n, start;
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        trig_data_rdy = 1'b0; trig_out_idle = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 req in reset", {31'd0, mem_req}, 32'd0);
        chk("R1 irq in reset", {31'd0, irq}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 req after reset", {31'd0, mem_req}, 32'd0);
        chk("R1 irq after reset", {31'd0, irq}, 32'd0);

        for (int i = 0; i < 6; i++) run_vector(i);

        // R9 / R2 / R11: held request, dropped trigger, busy write ignored
        start_job(32'h500, 32'h600, 2, 2'd0, 1'b0, 1'b0, 1, 2'd0, 0);
        gnt_hold = 1'b1;
        start = units_total;
        pulse(2'd0);
        chk("R9 request raised", {31'd0, mem_req}, 32'd1);
        pulse(2'd0);
        cfg_wr(REG_SRC, 32'h999);
        repeat (2) @(negedge clk);
        chk("R9 request held", {31'd0, mem_req}, 32'd1);
        chk("R9 src stable", mem_src, 32'h500);
        @(posedge clk);
        gnt_hold = 1'b0;
        @(negedge clk);
        wait_req_low();
        chk("R9 one unit granted", 32'(units_total - start), 32'd1);
        repeat (4) @(negedge clk);
        chk("R9 dropped trigger not queued", {31'd0, mem_req}, 32'd0);
        chk("R2 busy write ignored", mem_src, 32'h501);
        pulse(2'd0);
        wait_req_low();
        chk("R10 irq after last unit", {31'd0, irq}, 32'd1);
        repeat (3) @(negedge clk);
        chk("R11 irq sticky", {31'd0, irq}, 32'd1);
        cfg_wr(REG_IRQCLR, 32'd0);
        chk("R11 clear with 0 keeps irq", {31'd0, irq}, 32'd1);
        cfg_wr(REG_IRQCLR, 32'd1);
        chk("R11 clear with 1", {31'd0, irq}, 32'd0);

        // R5: timer spacing with reload 4
        start_job(32'h20, 32'h30, 2, 2'd2, 1'b0, 1'b0, 1, 2'd2, 4);
        n = 0;
        do begin @(posedge clk); n++; @(negedge clk); end while (!mem_req && n < 64);
        chk("R5 first request delay", 32'(n), 32'd5);
        n = 0;
        do begin @(posedge clk); n++; @(negedge clk); end while (!(mem_req && n > 1) && n < 64);
        chk("R5 request interval", 32'(n), 32'd5);
        wait_req_low();
        chk("R10 timer job irq", {31'd0, irq}, 32'd1);
        cfg_wr(REG_IRQCLR, 32'd1);

        // R12: zero count
        cfg_wr(REG_COUNT, 32'd0);
        cfg_wr(REG_CTRL, 32'h1);
        chk("R12 irq on zero count", {31'd0, irq}, 32'd1);
        pulse(2'd0);
        repeat (2) @(negedge clk);
        chk("R12 no request", {31'd0, mem_req}, 32'd0);
        cfg_wr(REG_IRQCLR, 32'd1);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests + s_tests, n_fail + s_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests + s_tests, n_fail + s_fail);
            $finish;
        end
    end

endmodule